// File: doc/BRIEF.md
# Register-Pair Word Increment Unit

This unit executes a single instruction: it adds one to a 16-bit word stored as two neighbouring bytes of an 8-bit register file, then updates three status flags. The first byte of the pair sits at an even address and is the most significant byte. The byte after it is the least significant byte.

An instruction is an opcode byte plus an operand byte. In pair mode the operand is itself the address of the pair. In pointer mode the operand names a register, and the byte stored in that register is the address of the pair. The unit takes eight cycles for either mode. It reads the two bytes one at a time, adds one, writes the two bytes back one at a time, and updates the flags in the final cycle.

The register file and the flag register are part of the unit. A host port can preload registers and flags while the unit is idle. A combinational host read port exposes any register. The flag register uses this layout: C in bit 7, Z in bit 6, S in bit 5, V in bit 4, D in bit 3 and H in bit 2. Bits 1:0 are spare.

Top module: `wordinc_unit`

## Requirements
- R1: After reset, `busy`, `done` and `addr_err` are 0 and `flags` is 8'h00.
- R2: Opcode 8'hA0 (pair mode) increments the 16-bit value held at address `operand` (high byte) and `operand`+1 (low byte). For example, 1Ah/02h becomes 1Ah/03h.
- R3: Opcode 8'hA1 (pointer mode) takes the pair address from the register named by `operand`. For example, with the pointer holding 02h, 0Fh/FFh at 02h/03h becomes 10h/00h.
- R4: The start edge that accepts an instruction counts as cycle 1. `busy` reads 1 from that edge until the 8th cycle. In the 8th cycle `done` is 1 for exactly that one cycle and `busy` is 0. The registers and flags already hold their results in that cycle.
- R5: Z (bit 6) is set when the 16-bit result is 0000h and cleared otherwise.
- R6: S (bit 5) equals bit 15 of the result.
- R7: V (bit 4) is set only when 7FFFh becomes 8000h.
- R8: C (bit 7), D (bit 3), H (bit 2) and bits 1:0 keep their values across the instruction.
- R9: An odd pair address, whether it comes from the operand or from the pointer register, has bit 0 cleared before use. `addr_err` then reads 1 from the cycle after acceptance until the next instruction is accepted.
- R10: FFFFh wraps to 0000h, which sets Z and clears S and V.
- R11: A `start` that arrives while `busy` is 1 is ignored. It produces no extra result and no extra `done`.
- R12: A `start` whose opcode is neither 8'hA0 nor 8'hA1 is not accepted: `busy` stays 0 and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an instruction |
| opcode | input | 8 | Instruction opcode (A0h pair, A1h pointer) |
| operand | input | AW | Pair address or pointer register address |
| host_we | input | 1 | Host register write enable (acts only when idle) |
| host_waddr | input | AW | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | AW | Host read address |
| host_rdata | output | 8 | Register contents at `host_raddr` (combinational) |
| flag_we | input | 1 | Flag register load (acts only when idle) |
| flag_wdata | input | 8 | Flag load value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_err | output | 1 | Odd pair address was seen for the current or last instruction |
| flags | output | 8 | Flag register |

## Verification
The bench counts its own clock edges. The edge that samples `start` is cycle 1, so `done` is expected in cycle 8. At that same point the bench expects the updated bytes and flags to be readable, and it checks `busy` one cycle after acceptance. A driver pushes each expected item onto a queue together with the cycle in which the item is due. A monitor samples on falling edges and pops one item per `done`. It compares the cycle number, the flags and `addr_err`, and then reads both bytes of the pair through the host read port before the driver acts again. A `done` that appears with an empty queue counts as a failure, and this is how ignored and rejected starts are checked.

// File: rtl/wordinc_pkg.sv
package wordinc_pkg;
    localparam int FLAG_C = 7;
    localparam int FLAG_Z = 6;
    localparam int FLAG_S = 5;
    localparam int FLAG_V = 4;
    localparam int FLAG_D = 3;
    localparam int FLAG_H = 2;

    localparam logic [7:0] OPC_PAIR = 8'hA0;
    localparam logic [7:0] OPC_PTR  = 8'hA1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PTR, ST_RDHI, ST_RDLO, ST_ADD, ST_WRHI, ST_WRLO, ST_FLAG
    } step_e;
endpackage

// File: rtl/wordinc_regfile.sv
module wordinc_regfile #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/wordinc_addrsel.sv
module wordinc_addrsel #(
    parameter int AW = 8
) (
    input  logic          indirect,
    input  logic [AW-1:0] opnd,
    input  logic [7:0]    ptr_byte,
    output logic [AW-1:0] even_addr,
    output logic          odd
);
    logic [AW-1:0] raw;

    always_comb begin
        raw       = indirect ? ptr_byte[AW-1:0] : opnd;
        odd       = raw[0];
        even_addr = {raw[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/wordinc_flagcalc.sv
module wordinc_flagcalc
    import wordinc_pkg::*;
(
    input  logic [7:0]  flags_in,
    input  logic [15:0] result,
    input  logic        old_msb,
    output logic [7:0]  flags_out
);
    always_comb begin
        flags_out         = flags_in;
        flags_out[FLAG_Z] = (result == 16'h0000);
        flags_out[FLAG_S] = result[15];
        flags_out[FLAG_V] = !old_msb && result[15];
    end
endmodule

// File: rtl/wordinc_unit.sv
module wordinc_unit
    import wordinc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] operand,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [7:0]    host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [7:0]    host_rdata,
    input  logic          flag_we,
    input  logic [7:0]    flag_wdata,
    output logic          busy,
    output logic          done,
    output logic          addr_err,
    output logic [7:0]    flags
);
    typedef struct packed {
        step_e         step;
        logic          indirect;
        logic [AW-1:0] opnd;
        logic [AW-1:0] addr;
        logic [15:0]   word;
        logic          old_msb;
        logic [7:0]    flags;
        logic          busy;
        logic          done;
        logic          err;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [AW-1:0] eng_raddr;
    logic [7:0]    eng_rdata;
    logic          rf_we;
    logic [AW-1:0] rf_waddr;
    logic [7:0]    rf_wdata;
    logic [AW-1:0] sel_addr;
    logic          sel_odd;
    logic [7:0]    flags_new;
    logic [AW-1:0] addr_lo;

    assign addr_lo = {st_q.addr[AW-1:1], 1'b1};

    wordinc_regfile #(.AW(AW)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (eng_raddr),
        .rdata_a (eng_rdata),
        .raddr_b (host_raddr),
        .rdata_b (host_rdata)
    );

    wordinc_addrsel #(.AW(AW)) u_sel (
        .indirect  (st_q.indirect),
        .opnd      (st_q.opnd),
        .ptr_byte  (eng_rdata),
        .even_addr (sel_addr),
        .odd       (sel_odd)
    );

    wordinc_flagcalc u_flg (
        .flags_in  (st_q.flags),
        .result    (st_q.word),
        .old_msb   (st_q.old_msb),
        .flags_out (flags_new)
    );

    // Engine read address and shared write port
    always_comb begin
        unique case (st_q.step)
            ST_RDHI: eng_raddr = st_q.addr;
            ST_RDLO: eng_raddr = addr_lo;
            default: eng_raddr = st_q.opnd;
        endcase

        rf_we    = 1'b0;
        rf_waddr = host_waddr;
        rf_wdata = host_wdata;
        if (st_q.step == ST_WRHI) begin
            rf_we    = 1'b1;
            rf_waddr = st_q.addr;
            rf_wdata = st_q.word[15:8];
        end else if (st_q.step == ST_WRLO) begin
            rf_we    = 1'b1;
            rf_waddr = addr_lo;
            rf_wdata = st_q.word[7:0];
        end else if (!st_q.busy) begin
            rf_we    = host_we;
        end
    end

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.step)
            ST_IDLE: begin
                if (flag_we) st_d.flags = flag_wdata;
                if (start && (opcode == OPC_PAIR || opcode == OPC_PTR)) begin
                    st_d.step     = ST_PTR;
                    st_d.indirect = (opcode == OPC_PTR);
                    st_d.opnd     = operand;
                    st_d.busy     = 1'b1;
                    st_d.err      = 1'b0;
                end
            end
            ST_PTR: begin
                st_d.addr = sel_addr;
                st_d.err  = sel_odd;
                st_d.step = ST_RDHI;
            end
            ST_RDHI: begin
                st_d.word[15:8] = eng_rdata;
                st_d.step       = ST_RDLO;
            end
            ST_RDLO: begin
                st_d.word[7:0] = eng_rdata;
                st_d.step      = ST_ADD;
            end
            ST_ADD: begin
                st_d.old_msb = st_q.word[15];
                st_d.word    = st_q.word + 16'd1;
                st_d.step    = ST_WRHI;
            end
            ST_WRHI: st_d.step = ST_WRLO;
            ST_WRLO: st_d.step = ST_FLAG;
            ST_FLAG: begin
                st_d.flags = flags_new;
                st_d.done  = 1'b1;
                st_d.busy  = 1'b0;
                st_d.step  = ST_IDLE;
            end
            default: st_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign addr_err = st_q.err;
    assign flags    = st_q.flags;
endmodule

// File: rtl/wordinc_checker.sv
module wordinc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [7:0]  flags,
    input logic [15:0] word
);
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[6] == (word == 16'h0000)));

    p_sign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[5] == word[15]));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[4] == (word == 16'h8000)));

    p_keep_cdh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[7] == $past(flags[7]) && flags[3:2] == $past(flags[3:2])
                  && flags[1:0] == $past(flags[1:0])));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(flags));
endmodule

bind wordinc_unit wordinc_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .flags (flags),
    .word  (st_q.word)
);

// File: tb/wordinc_unit_tb.sv
module wordinc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [AW-1:0] operand = '0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_waddr = '0;
    logic [7:0]    host_wdata = '0;
    logic [AW-1:0] host_raddr = '0;
    logic [7:0]    host_rdata;
    logic          flag_we = 1'b0;
    logic [7:0]    flag_wdata = '0;
    logic          busy, done, addr_err;
    logic [7:0]    flags;

    wordinc_unit #(.AW(AW)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] fl;
        logic       err;
        int         due;
        string      req;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] mem [256];
    logic [7:0] fl_m = 8'h00;
    int         cyc = 0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mem[a] = d;
    endtask

    task automatic flag_wr(input logic [7:0] d);
        @(negedge clk);
        flag_we = 1'b1; flag_wdata = d;
        @(negedge clk);
        flag_we = 1'b0;
        fl_m = d;
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] opnd,
                         input string req, input bit poke_busy);
        exp_t e;
        logic [7:0]  ptr;
        logic [15:0] old, nw;
        ptr    = (op == 8'hA1) ? mem[opnd] : opnd;
        e.err  = ptr[0];
        e.addr = {ptr[7:1], 1'b0};
        old    = {mem[e.addr], mem[e.addr + 8'd1]};
        nw     = old + 16'd1;
        mem[e.addr]        = nw[15:8];
        mem[e.addr + 8'd1] = nw[7:0];
        fl_m[6] = (nw == 16'h0000);
        fl_m[5] = nw[15];
        fl_m[4] = (old == 16'h7FFF);
        e.hi  = nw[15:8];
        e.lo  = nw[7:0];
        e.fl  = fl_m;
        e.req = req;
        @(negedge clk);
        start = 1'b1; opcode = op; operand = opnd;
        e.due = cyc + 8;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 busy after accept", busy, 1);
        if (poke_busy) begin
            // R11: extra start while busy must be ignored
            start = 1'b1; opcode = 8'hA0; operand = opnd ^ 8'h08;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11/R12 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(cyc == e.due, "R4 done cycle", cyc, e.due);
                    chk(busy == 1'b0, "R4 busy low at done", busy, 0);
                    chk(flags == e.fl, {e.req, " R5/R6/R7/R8 flags"}, flags, e.fl);
                    chk(addr_err == e.err, {e.req, " R9 addr_err"}, addr_err, e.err);
                    host_raddr = e.addr;
                    #1;
                    chk(host_rdata == e.hi, {e.req, " high byte"}, host_rdata, e.hi);
                    host_raddr = e.addr + 8'd1;
                    #1;
                    chk(host_rdata == e.lo, {e.req, " low byte"}, host_rdata, e.lo);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(addr_err == 1'b0, "R1 addr_err", addr_err, 0);
        chk(flags == 8'h00, "R1 flags", flags, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) host_wr(i[7:0], 8'(i * 37 + 11));

        // R2: direct pair 1A/02 -> 1A/03
        host_wr(8'h20, 8'h1A); host_wr(8'h21, 8'h02);
        issue(8'hA0, 8'h20, "R2 direct", 1'b0);

        // R3: pointer 02h, 0F/FF -> 10/00
        host_wr(8'h02, 8'h0F); host_wr(8'h03, 8'hFF); host_wr(8'h10, 8'h02);
        issue(8'hA1, 8'h10, "R3 indirect", 1'b0);

        // R10 / R5: FFFF wraps to 0000 with C,D,H preset to 1
        flag_wr(8'hFF);
        host_wr(8'h40, 8'hFF); host_wr(8'h41, 8'hFF);
        issue(8'hA0, 8'h40, "R10 wrap", 1'b0);

        // R7 / R6: 7FFF -> 8000, R8 with other preset pattern
        flag_wr(8'h8E);
        host_wr(8'h42, 8'h7F); host_wr(8'h43, 8'hFF);
        issue(8'hA0, 8'h42, "R7 overflow", 1'b0);
        issue(8'hA0, 8'h42, "R6 negative no overflow", 1'b0);

        // R9: odd direct and odd pointer
        issue(8'hA0, 8'h45, "R9 odd direct", 1'b0);
        host_wr(8'h11, 8'h47);
        issue(8'hA1, 8'h11, "R9 odd pointer", 1'b0);
        issue(8'hA0, 8'h44, "R9 even clears", 1'b0);

        // R11: start while busy ignored
        issue(8'hA0, 8'h50, "R11 busy poke", 1'b1);
        repeat (12) @(negedge clk);
        chk(busy == 1'b0, "R11 stays idle", busy, 0);

        // R12: unknown opcode not accepted
        @(negedge clk);
        start = 1'b1; opcode = 8'h55; operand = 8'h60;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R12 unknown opcode", busy, 0);
        host_raddr = 8'h60; #1;
        chk(host_rdata == mem[8'h60], "R12 register untouched", host_rdata, mem[8'h60]);
        repeat (10) @(negedge clk);

        // Random mix of modes and operands
        for (int k = 0; k < 24; k++) begin
            if (k % 5 == 0) flag_wr(8'($urandom));
            issue(($urandom % 2) ? 8'hA1 : 8'hA0, 8'($urandom), "R2/R3 random", 1'b0);
        end

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule